// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits on the receive byte stream of an Ethernet MAC and decides whether each frame is kept. It looks at the first six bytes of the frame, which hold the destination address, and classes the frame as unicast, multicast or broadcast. It then runs two filter stages in a row. The first stage checks against one programmed unicast address, two reject controls and a small set of exact multicast entries. A promiscuous setting bypasses this first stage. The optional second stage checks against a second unicast address and a 32768-bit multicast hash table. It also always refuses one fixed multicast prefix.

A frame that fails on its address is dropped one cycle after its sixth byte. Any bytes it still has are ignored. A frame that passes gets its final verdict one cycle after its last byte. At that point the length rules apply: frames that are too short are rejected, and frames in the tagged/oversize band are dropped unless enabled. Accepted frames update four 64-bit statistics counters. Software programs the block through a simple write-only register port.

Top module: `rx_dst_filter`

## Requirements
- R1: Class encoding on `class_o` is valid with `accept_o`: 0 = unicast (bit 0 of byte 0 clear), 2 = broadcast (all six bytes 0xFF), 1 = multicast (anything else).
- R2: An address entry is two registers. Destination bytes 0..3 equal the low register read little-endian (byte 0 in bits 7:0). Bytes 4..5 equal bits 15:0 of the high register. Outside promiscuous mode, a unicast frame passes the first stage only if it equals the unicast entry (registers 0x002/0x003).
- R3: Control register 0x000: bit 2 set drops broadcast frames and bit 1 set drops multicast frames, in the first stage.
- R4: The first stage passes a multicast frame only if it equals one of four multicast entries. Register 0x001 bits 1:0 pick which entry the entry registers 0x006/0x007 write.
- R5: Register 0x001 bit 31 set selects promiscuous mode, which skips the first stage entirely.
- R6: The second stage is active only when control bits 11 and 12 are both set. When active, a unicast frame must equal the extended unicast entry (0x004/0x005), and a broadcast frame is dropped when control bit 2 is set.
- R7: In the active second stage, a multicast frame starting 01-00-52 is dropped. Any other multicast frame forms index = (byte4 & 0x7F)*256 + byte5 and is dropped unless bit index[4:0] of hash word index[14:5] is set. Hash word w is written at register 0x400+w.
- R8: Frames of 1519 to 1522 bytes are dropped unless register 0x008 bit 0 (oversize enable) or bit 1 (tag enable) is set.
- R9: A frame under 12 bytes that has not already been dropped on its address is dropped and sets `reject_o`. `reject_o` stays set until a write to register 0x009 with bit 3 set.
- R10: An address failure pulses `drop_o` for one cycle, the cycle after the sixth byte, and the rest of that frame yields no further pulse. Otherwise exactly one of `accept_o`/`drop_o` pulses the cycle after the last byte.
- R11: On accept, `frames_o` increments by one and `bytes_o` by the frame length. `mcast_cnt_o` or `bcast_cnt_o` increments by one for multicast or broadcast frames. The counters update in the same cycle `accept_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 11 | Register word address |
| cfg_wdata_i | input | 32 | Register write data |
| rx_valid_i | input | 1 | Receive byte valid |
| rx_data_i | input | 8 | Receive byte |
| rx_last_i | input | 1 | Marks the last byte of a frame |
| accept_o | output | 1 | Frame accepted pulse |
| drop_o | output | 1 | Frame dropped pulse |
| class_o | output | 2 | Frame class (R1 encoding) |
| reject_o | output | 1 | Sticky short-frame reject status |
| frames_o | output | 64 | Accepted frame count |
| bytes_o | output | 64 | Accepted byte count |
| mcast_cnt_o | output | 64 | Accepted multicast count |
| bcast_cnt_o | output | 64 | Accepted broadcast count |

## Verification
The bench builds the block with its default parameters: four multicast entries, a 16-bit length counter and 64-bit counters. The 16-bit length reaches the 1518/1519 and 1522/1523 edges of the length band. Four entries let the test write a non-zero entry through the index selector. A behavioural model compares the pulses, the sticky reject bit and all four counters on every clock. Its stimulus includes frames that end on exactly the sixth byte, frames shorter than the address, and frames that pass the first stage only to be refused by the hash table.

// File: rtl/rx_dst_filter_pkg.sv
package rx_dst_filter_pkg;
  localparam int REG_AW     = 11;
  localparam int HASH_IW    = 15;
  localparam int HASH_WORDS = 1 << (HASH_IW - 5);

  localparam logic [REG_AW-1:0] RA_CTRL  = 11'h000;
  localparam logic [REG_AW-1:0] RA_FIDX  = 11'h001;
  localparam logic [REG_AW-1:0] RA_UC_LO = 11'h002;
  localparam logic [REG_AW-1:0] RA_UC_HI = 11'h003;
  localparam logic [REG_AW-1:0] RA_XU_LO = 11'h004;
  localparam logic [REG_AW-1:0] RA_XU_HI = 11'h005;
  localparam logic [REG_AW-1:0] RA_MC_LO = 11'h006;
  localparam logic [REG_AW-1:0] RA_MC_HI = 11'h007;
  localparam logic [REG_AW-1:0] RA_RXCFG = 11'h008;
  localparam logic [REG_AW-1:0] RA_STAT  = 11'h009;

  typedef enum logic [1:0] {
    CLS_UC = 2'd0,
    CLS_MC = 2'd1,
    CLS_BC = 2'd2
  } frm_class_e;

  typedef struct packed {
    logic [15:0] hi;
    logic [31:0] lo;
  } addr_ent_t;
endpackage

// File: rtl/rx_dst_filter_cfg.sv
module rx_dst_filter_cfg
  import rx_dst_filter_pkg::*;
#(
  parameter int MC_ENTRIES = 4,
  localparam int SEL_W = (MC_ENTRIES > 1) ? $clog2(MC_ENTRIES) : 1
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          we_i,
  input  logic [REG_AW-1:0]             addr_i,
  input  logic [31:0]                   wdata_i,
  input  logic [HASH_IW-1:0]            hash_idx_i,
  output logic                          bc_rej_o,
  output logic                          mc_rej_o,
  output logic                          ext_on_o,
  output logic                          promisc_o,
  output addr_ent_t                     uc_o,
  output addr_ent_t                     xuc_o,
  output addr_ent_t [MC_ENTRIES-1:0]    mc_o,
  output logic                          jumbo_en_o,
  output logic                          vlan_en_o,
  output logic                          hash_bit_o,
  output logic                          rej_clr_o
);
  logic [31:0] hash_mem [HASH_WORDS];
  logic        newf_q, xmc_q;
  logic [SEL_W-1:0] sel_q;
  logic        hash_we;

  assign hash_we = we_i && addr_i[REG_AW-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bc_rej_o   <= 1'b0;
      mc_rej_o   <= 1'b0;
      newf_q     <= 1'b0;
      xmc_q      <= 1'b0;
      promisc_o  <= 1'b0;
      sel_q      <= '0;
      uc_o       <= '0;
      xuc_o      <= '0;
      mc_o       <= '0;
      jumbo_en_o <= 1'b0;
      vlan_en_o  <= 1'b0;
    end else if (we_i && !hash_we) begin
      unique case (addr_i)
        RA_CTRL: begin
          mc_rej_o <= wdata_i[1];
          bc_rej_o <= wdata_i[2];
          newf_q   <= wdata_i[11];
          xmc_q    <= wdata_i[12];
        end
        RA_FIDX: begin
          promisc_o <= wdata_i[31];
          sel_q     <= wdata_i[SEL_W-1:0];
        end
        RA_UC_LO: uc_o.lo  <= wdata_i;
        RA_UC_HI: uc_o.hi  <= wdata_i[15:0];
        RA_XU_LO: xuc_o.lo <= wdata_i;
        RA_XU_HI: xuc_o.hi <= wdata_i[15:0];
        RA_MC_LO: mc_o[sel_q].lo <= wdata_i;
        RA_MC_HI: mc_o[sel_q].hi <= wdata_i[15:0];
        RA_RXCFG: begin
          jumbo_en_o <= wdata_i[0];
          vlan_en_o  <= wdata_i[1];
        end
        default: ;
      endcase
    end
  end

  // Table is not reset; software must load it before enabling the stage.
  always_ff @(posedge clk_i) begin
    if (hash_we) hash_mem[addr_i[HASH_IW-6:0]] <= wdata_i;
  end

  assign ext_on_o   = newf_q && xmc_q;
  assign hash_bit_o = hash_mem[hash_idx_i[HASH_IW-1:5]][hash_idx_i[4:0]];
  assign rej_clr_o  = we_i && (addr_i == RA_STAT) && wdata_i[3];
endmodule

// File: rtl/rx_dst_filter_match.sv
module rx_dst_filter_match
  import rx_dst_filter_pkg::*;
#(
  parameter int MC_ENTRIES = 4
) (
  input  logic [47:0]                da_i,
  input  logic                       bc_rej_i,
  input  logic                       mc_rej_i,
  input  logic                       ext_on_i,
  input  logic                       promisc_i,
  input  addr_ent_t                  uc_i,
  input  addr_ent_t                  xuc_i,
  input  addr_ent_t [MC_ENTRIES-1:0] mc_i,
  input  logic                       hash_bit_i,
  output logic [HASH_IW-1:0]         hash_idx_o,
  output frm_class_e                 cls_o,
  output logic                       pass_o
);
  logic is_uc, is_bc, is_mc, ip_pfx;
  logic uc_hit, xuc_hit;
  logic [MC_ENTRIES-1:0] mc_hit;
  logic basic_ok, ext_ok;

  assign is_uc  = ~da_i[0];
  assign is_bc  = &da_i;
  assign is_mc  = !is_uc && !is_bc;
  assign ip_pfx = (da_i[23:0] == 24'h52_00_01);

  assign uc_hit  = (da_i == {uc_i.hi, uc_i.lo});
  assign xuc_hit = (da_i == {xuc_i.hi, xuc_i.lo});

  for (genvar g = 0; g < MC_ENTRIES; g++) begin : g_mc
    assign mc_hit[g] = (da_i == {mc_i[g].hi, mc_i[g].lo});
  end

  assign hash_idx_o = {da_i[38:32], da_i[47:40]};

  always_comb begin
    if (promisc_i)  basic_ok = 1'b1;
    else if (is_uc) basic_ok = uc_hit;
    else if (is_bc) basic_ok = !bc_rej_i;
    else            basic_ok = !mc_rej_i && |mc_hit;

    if (!ext_on_i)  ext_ok = 1'b1;
    else if (is_uc) ext_ok = xuc_hit;
    else if (is_bc) ext_ok = !bc_rej_i;
    else            ext_ok = !ip_pfx && hash_bit_i;
  end

  assign pass_o = basic_ok && ext_ok;
  assign cls_o  = is_bc ? CLS_BC : (is_mc ? CLS_MC : CLS_UC);
endmodule

// File: rtl/rx_dst_filter_cnt.sv
module rx_dst_filter_cnt
  import rx_dst_filter_pkg::*;
#(
  parameter int CNT_W = 64,
  parameter int LEN_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic [LEN_W-1:0] len_i,
  input  frm_class_e       cls_i,
  output logic [CNT_W-1:0] frames_o,
  output logic [CNT_W-1:0] bytes_o,
  output logic [CNT_W-1:0] mc_o,
  output logic [CNT_W-1:0] bc_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frames_o <= '0;
      bytes_o  <= '0;
      mc_o     <= '0;
      bc_o     <= '0;
    end else if (inc_i) begin
      frames_o <= frames_o + 1'b1;
      bytes_o  <= bytes_o + CNT_W'(len_i);
      if (cls_i == CLS_MC) mc_o <= mc_o + 1'b1;
      if (cls_i == CLS_BC) bc_o <= bc_o + 1'b1;
    end
  end

  // R11
  idle_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inc_i |=> $stable(frames_o) && $stable(bytes_o));

  // R11
  class_sum_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mc_o + bc_o) <= frames_o);
endmodule

// File: rtl/rx_dst_filter.sv
module rx_dst_filter
  import rx_dst_filter_pkg::*;
#(
  parameter int MC_ENTRIES = 4,
  parameter int LEN_W      = 16,
  parameter int CNT_W      = 64,
  parameter int MIN_LEN    = 12,
  parameter int BAND_LO    = 1519,
  parameter int BAND_HI    = 1522
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [10:0]       cfg_addr_i,
  input  logic [31:0]       cfg_wdata_i,
  input  logic              rx_valid_i,
  input  logic [7:0]        rx_data_i,
  input  logic              rx_last_i,
  output logic              accept_o,
  output logic              drop_o,
  output logic [1:0]        class_o,
  output logic              reject_o,
  output logic [CNT_W-1:0]  frames_o,
  output logic [CNT_W-1:0]  bytes_o,
  output logic [CNT_W-1:0]  mcast_cnt_o,
  output logic [CNT_W-1:0]  bcast_cnt_o
);
  localparam int DA_BYTES = 6;
  localparam logic [LEN_W-1:0] LEN_MAX  = '1;
  localparam logic [LEN_W-1:0] ADDR_END = LEN_W'(DA_BYTES - 1);

  logic bc_rej, mc_rej, ext_on, promisc, jumbo_en, vlan_en, hash_bit, rej_clr;
  addr_ent_t uc, xuc;
  addr_ent_t [MC_ENTRIES-1:0] mc;
  logic [HASH_IW-1:0] hash_idx;
  frm_class_e cls, cls_q;
  logic pass;

  logic [LEN_W-1:0] len_q, n_len;
  logic [47:0] da_q, da_next;
  logic dead_q;
  logic at_addr_end, addr_bad, final_ev, short_f, band_f, acc_ev;

  rx_dst_filter_cfg #(.MC_ENTRIES(MC_ENTRIES)) u_cfg (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .addr_i(cfg_addr_i), .wdata_i(cfg_wdata_i),
    .hash_idx_i(hash_idx),
    .bc_rej_o(bc_rej), .mc_rej_o(mc_rej), .ext_on_o(ext_on),
    .promisc_o(promisc), .uc_o(uc), .xuc_o(xuc), .mc_o(mc),
    .jumbo_en_o(jumbo_en), .vlan_en_o(vlan_en),
    .hash_bit_o(hash_bit), .rej_clr_o(rej_clr)
  );

  always_comb begin
    da_next = da_q;
    if (len_q < LEN_W'(DA_BYTES)) da_next[{len_q[2:0], 3'b000} +: 8] = rx_data_i;
  end

  rx_dst_filter_match #(.MC_ENTRIES(MC_ENTRIES)) u_match (
    .da_i(da_next), .bc_rej_i(bc_rej), .mc_rej_i(mc_rej), .ext_on_i(ext_on),
    .promisc_i(promisc), .uc_i(uc), .xuc_i(xuc), .mc_i(mc),
    .hash_bit_i(hash_bit), .hash_idx_o(hash_idx), .cls_o(cls), .pass_o(pass)
  );

  assign n_len       = (len_q == LEN_MAX) ? len_q : len_q + 1'b1;
  assign at_addr_end = rx_valid_i && (len_q == ADDR_END);
  assign addr_bad    = at_addr_end && !pass;
  assign final_ev    = rx_valid_i && rx_last_i && !dead_q && !addr_bad;
  assign short_f     = n_len < LEN_W'(MIN_LEN);
  assign band_f      = (n_len >= LEN_W'(BAND_LO)) && (n_len <= LEN_W'(BAND_HI))
                       && !jumbo_en && !vlan_en;
  assign acc_ev      = final_ev && !short_f && !band_f;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q    <= '0;
      da_q     <= '0;
      dead_q   <= 1'b0;
      cls_q    <= CLS_UC;
      accept_o <= 1'b0;
      drop_o   <= 1'b0;
      reject_o <= 1'b0;
    end else begin
      accept_o <= acc_ev;
      drop_o   <= addr_bad || (final_ev && !acc_ev);
      if (rej_clr) reject_o <= 1'b0;
      if (final_ev && short_f) reject_o <= 1'b1;
      if (rx_valid_i) begin
        da_q <= da_next;
        if (at_addr_end) cls_q <= cls;
        if (rx_last_i) begin
          len_q  <= '0;
          dead_q <= 1'b0;
        end else begin
          len_q <= n_len;
          if (addr_bad) dead_q <= 1'b1;
        end
      end
    end
  end

  assign class_o = cls_q;

  rx_dst_filter_cnt #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_cnt (
    .clk_i, .rst_ni, .inc_i(acc_ev), .len_i(n_len), .cls_i(cls_q),
    .frames_o(frames_o), .bytes_o(bytes_o), .mc_o(mcast_cnt_o), .bc_o(bcast_cnt_o)
  );

  // R10
  verdict_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(accept_o && drop_o));

  // R10
  accept_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |=> !accept_o);

  // R9
  reject_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(reject_o) |-> drop_o);

  // R11
  accept_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |-> frames_o == $past(frames_o) + 1'b1);
endmodule

// File: tb/rx_dst_filter_tb.sv
module rx_dst_filter_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [10:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic rx_valid = 1'b0, rx_last = 1'b0;
  logic [7:0] rx_data = '0;
  logic accept, drop, reject;
  logic [1:0] cls_o;
  logic [63:0] frames, bytes_c, mcnt, bcnt;

  always #10 clk = ~clk;

  rx_dst_filter u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata),
    .rx_valid_i(rx_valid), .rx_data_i(rx_data), .rx_last_i(rx_last),
    .accept_o(accept), .drop_o(drop), .class_o(cls_o), .reject_o(reject),
    .frames_o(frames), .bytes_o(bytes_c), .mcast_cnt_o(mcnt), .bcast_cnt_o(bcnt)
  );

  int total = 0, bad = 0;
  bit done = 1'b0;

  // behavioural reference state
  logic [31:0] m_ctrl = '0, m_fidx = '0, m_rxcfg = '0;
  logic [31:0] m_uc [2];
  logic [31:0] m_xuc [2];
  logic [31:0] m_mc [4][2];
  logic [31:0] m_hash [1024];
  logic [63:0] rf = '0, rb = '0, rmc = '0, rbc = '0;
  bit rrej = 1'b0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint unsigned act, input longint unsigned exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [47:0] mk(input logic [7:0] b0, b1, b2, b3, b4, b5);
    return {b5, b4, b3, b2, b1, b0};
  endfunction

  function automatic bit hit(input logic [47:0] da, input logic [31:0] w0, w1);
    for (int i = 0; i < 4; i++)
      if (da[8*i +: 8] != w0[8*i +: 8]) return 1'b0;
    return (da[39:32] == w1[7:0]) && (da[47:40] == w1[15:8]);
  endfunction

  function automatic bit m_pass(input logic [47:0] da, output int cls);
    bit uc, bc, ok;
    int idx;
    uc = (da[0] == 1'b0);
    bc = (da == 48'hFFFF_FFFF_FFFF);
    cls = uc ? 0 : (bc ? 2 : 1);
    ok = 1'b1;
    if (!m_fidx[31]) begin
      if (uc) ok = hit(da, m_uc[0], m_uc[1]);
      else if (bc) ok = !m_ctrl[2];
      else begin
        bit any = 1'b0;
        for (int e = 0; e < 4; e++) if (hit(da, m_mc[e][0], m_mc[e][1])) any = 1'b1;
        ok = !m_ctrl[1] && any;
      end
    end
    if (ok && m_ctrl[11] && m_ctrl[12]) begin
      if (uc) ok = hit(da, m_xuc[0], m_xuc[1]);
      else if (bc) ok = !m_ctrl[2];
      else if (da[7:0] == 8'h01 && da[15:8] == 8'h00 && da[23:16] == 8'h52) ok = 1'b0;
      else begin
        idx = (int'(da[39:32]) % 128) * 256 + int'(da[47:40]);
        ok = m_hash[idx / 32][idx % 32];
      end
    end
    return ok;
  endfunction

  task automatic cfg_write(input int addr, input logic [31:0] data);
    case (addr)
      0: m_ctrl = data;
      1: m_fidx = data;
      2: m_uc[0] = data;
      3: m_uc[1] = data;
      4: m_xuc[0] = data;
      5: m_xuc[1] = data;
      6: m_mc[m_fidx[1:0]][0] = data;
      7: m_mc[m_fidx[1:0]][1] = data;
      8: m_rxcfg = data;
      9: if (data[3]) rrej = 1'b0;
      default: if (addr >= 'h400) m_hash[addr - 'h400] = data;
    endcase
    cfg_we = 1'b1; cfg_addr = 11'(addr); cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cmp_all(input string tag, input bit eacc, input bit edrop, input int ecls);
    chk({accept, drop} == {eacc, edrop}, tag, "accept/drop", {accept, drop}, {eacc, edrop});
    chk(reject == rrej, "R9", "reject", reject, rrej);
    chk(frames == rf && bytes_c == rb, "R11", "frames/bytes", frames ^ bytes_c, rf ^ rb);
    chk(mcnt == rmc && bcnt == rbc, "R11", "mcast/bcast", {mcnt[31:0], bcnt[31:0]},
        {rmc[31:0], rbc[31:0]});
    if (eacc) chk(int'(cls_o) == ecls, "R1", "class", cls_o, ecls);
  endtask

  task automatic send_frame(input logic [47:0] da, input int n, input string tag);
    bit ap, eacc, edrop;
    int cls;
    ap = m_pass(da, cls);
    for (int k = 0; k < n; k++) begin
      rx_valid = 1'b1;
      rx_data  = (k < 6) ? da[8*k +: 8] : 8'((k * 7 + 3) % 256);
      rx_last  = (k == n - 1);
      @(negedge clk);
      eacc = 1'b0; edrop = 1'b0;
      if (k == 5 && !ap) edrop = 1'b1;
      else if (k == n - 1 && (n < 6 || ap)) begin
        if (n < 12) begin edrop = 1'b1; rrej = 1'b1; end
        else if (n >= 1519 && n <= 1522 && !m_rxcfg[0] && !m_rxcfg[1]) edrop = 1'b1;
        else begin
          eacc = 1'b1;
          rf++; rb += 64'(n);
          if (cls == 1) rmc++;
          if (cls == 2) rbc++;
        end
      end
      if (k == n - 1) begin rx_valid = 1'b0; rx_last = 1'b0; end
      cmp_all(tag, eacc, edrop, cls);
    end
    @(negedge clk);
    cmp_all("R10", 1'b0, 1'b0, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic [47:0] ucda, xda, mcda, hda;
    for (int i = 0; i < 1024; i++) m_hash[i] = '0;
    for (int i = 0; i < 2; i++) begin m_uc[i] = '0; m_xuc[i] = '0; end
    for (int e = 0; e < 4; e++) begin m_mc[e][0] = '0; m_mc[e][1] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    cmp_all("R10", 1'b0, 1'b0, 0);
    chk(reject == 1'b0, "R9", "reset reject", reject, 0);

    // for hash words the RTL memory must be loaded before use
    for (int w = 0; w < 64; w++) cfg_write('h400 + w, 32'h0);

    ucda = mk(8'h02, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55);
    cfg_write(2, 32'h3322_1102);
    cfg_write(3, 32'h0000_5544);
    send_frame(ucda, 20, "R2");
    send_frame(mk(8'h02, 8'h11, 8'h22, 8'h33, 8'h44, 8'h56), 20, "R2");
    send_frame(mk(8'h02, 8'h11, 8'h22, 8'h34, 8'h44, 8'h55), 6, "R10");

    send_frame(48'hFFFF_FFFF_FFFF, 16, "R1");
    cfg_write(0, 32'h4);
    send_frame(48'hFFFF_FFFF_FFFF, 16, "R3");
    cfg_write(0, 32'h0);

    mcda = mk(8'h01, 8'h00, 8'h5E, 8'h00, 8'h00, 8'h07);
    cfg_write(1, 32'h2);
    cfg_write(6, 32'h005E_0001);
    cfg_write(7, 32'h0000_0700);
    send_frame(mcda, 30, "R4");
    send_frame(mk(8'h01, 8'h00, 8'h5E, 8'h00, 8'h00, 8'h08), 30, "R4");
    cfg_write(0, 32'h2);
    send_frame(mcda, 30, "R3");
    cfg_write(0, 32'h0);

    cfg_write(1, 32'h8000_0000);
    send_frame(mk(8'h0A, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05), 14, "R5");
    send_frame(mk(8'h03, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05), 14, "R5");

    xda = mk(8'h02, 8'hAA, 8'hBB, 8'hCC, 8'hDD, 8'hEE);
    cfg_write(4, 32'hCCBB_AA02);
    cfg_write(5, 32'h0000_EEDD);
    cfg_write(0, 32'h0000_0800);
    send_frame(ucda, 14, "R6");
    cfg_write(0, 32'h0000_1800);
    send_frame(ucda, 14, "R6");
    send_frame(xda, 14, "R6");
    cfg_write(0, 32'h0000_1804);
    send_frame(48'hFFFF_FFFF_FFFF, 14, "R6");
    cfg_write(0, 32'h0000_1800);
    send_frame(mk(8'h01, 8'h00, 8'h52, 8'h00, 8'h00, 8'h00), 14, "R7");
    hda = mk(8'h01, 8'h22, 8'h33, 8'h44, 8'h85, 8'h3C);
    send_frame(hda, 14, "R7");
    cfg_write('h400 + 41, 32'h1000_0000);
    send_frame(hda, 14, "R7");
    cfg_write('h400 + 41, 32'hEFFF_FFFF);
    send_frame(hda, 14, "R7");
    cfg_write(0, 32'h0);
    cfg_write(1, 32'h0);

    send_frame(ucda, 1518, "R8");
    send_frame(ucda, 1519, "R8");
    send_frame(ucda, 1522, "R8");
    send_frame(ucda, 1523, "R8");
    cfg_write(8, 32'h1);
    send_frame(ucda, 1520, "R8");
    cfg_write(8, 32'h2);
    send_frame(ucda, 1521, "R8");
    cfg_write(8, 32'h0);

    send_frame(ucda, 11, "R9");
    cfg_write(9, 32'h0);
    chk(reject == 1'b1, "R9", "clear without bit3", reject, 1);
    cfg_write(9, 32'h8);
    chk(reject == 1'b0, "R9", "clear", reject, 0);
    send_frame(ucda, 12, "R9");
    send_frame(ucda, 3, "R9");
    send_frame(mk(8'h02, 8'h11, 8'h22, 8'h33, 8'h44, 8'h99), 8, "R10");

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule